// File: doc/BRIEF.md
# Edge-Triggered Three-State Phase-Frequency Detector

This block compares a reference clock against a feedback clock and tells an external charge pump which way to steer the loop. Both inputs are asynchronous to the system clock. Each one first passes through its own synchroniser chain, and only then does it reach the decision logic. Only rising edges steer the result, so the high and low times of either input do not matter.

The decision logic is a twelve-state machine. A state is the pump mode (raise, lower or idle) paired with the last seen level of each input. A reference rise while idle starts a raise request, and the next feedback rise ends it. A feedback rise while idle starts a lower request, and the next reference rise ends it. Equal frequencies with a phase offset give a request as long as the offset. A frequency mismatch holds one request for most of the time. When the edges line up, the detector stays idle, which leaves the loop filter voltage where it is.

The pump command is two enables that are never high together. Both low means the pump output is high-impedance. A separate idle flag is high exactly while neither enable is high, and it can be used as a lock indication.

Top module: `pfd_core`

## Requirements
- R1: Only rising edges of the synchronised inputs change the pump mode. Falling edges and the high or low time of either input have no effect on the outputs.
- R2: A reference rise while idle sets `up_o`=1. The next feedback rise clears it. With equal periods and the reference leading by D cycles, `up_o` is high for exactly D cycles per period.
- R3: A feedback rise while idle sets `dn_o`=1. The next reference rise clears it. With equal periods and the feedback leading by D cycles, `dn_o` is high for exactly D cycles per period.
- R4: Rises on both inputs seen in the same clock cycle put the detector in the idle mode, whatever mode it was in. Coincident edges therefore leave both enables low.
- R5: `lock_o` is 1 exactly when `up_o` and `dn_o` are both 0, and is 0 otherwise.
- R6: `up_o` and `dn_o` are never 1 together. The value `up_o`=0 with `dn_o`=0 means high-impedance.
- R7: Repeated rises of one input with no rise of the other keep the matching enable asserted. With no reference edges and feedback edges arriving, `dn_o` stays 1. With the reference faster than the feedback, `dn_o` never asserts.
- R8: While `rst` is high at a clock edge, the detector goes idle with both input levels taken as low. The outputs then read `up_o`=0, `dn_o`=0, `lock_o`=1.
- R9: A rising edge at an input port reaches the outputs after SYNC_STAGES+1 clock edges, plus one more when OUT_REG=1. The defaults give three edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock |
| rst | input | 1 | Synchronous reset, active high |
| ref_i | input | 1 | Reference clock, asynchronous |
| fbk_i | input | 1 | Feedback clock, asynchronous |
| up_o | output | 1 | Pump raise enable |
| dn_o | output | 1 | Pump lower enable |
| lock_o | output | 1 | High while both enables are low |

## Verification
Two events can land on the same clock cycle: a reference rise and a feedback rise. Each of them alone would start or end a request. Together they must force the idle mode, whether the detector was idle, raising or lowering at that moment. The bench provokes this in three ways. It drives two streams with identical edge timing. It sets both inputs high together while a raise request is active. It also lets random toggling line the edges up by chance. The result is judged cycle by cycle against a reference mode model inside the bench, and by the requirement that `lock_o` stays high throughout an aligned stream.

// File: rtl/pfd_pkg.sv
package pfd_pkg;

   // Pump command carried by the state machine
   typedef enum logic [1:0] {
      PUMP_OFF = 2'b00,
      PUMP_UP  = 2'b01,
      PUMP_DN  = 2'b10
   } pump_e;

   // Twelve reachable states: three pump modes times two tracked input levels
   typedef struct packed {
      pump_e mode;
      logic  ref_lvl;
      logic  fbk_lvl;
   } pfd_state_t;

   localparam pfd_state_t PFD_IDLE_STATE = '{mode: PUMP_OFF, ref_lvl: 1'b0, fbk_lvl: 1'b0};

   // Mode step on the rising-edge pulses of one cycle
   function automatic pump_e pfd_step(pump_e cur, logic rise_ref, logic rise_fbk);
      pump_e nxt;
      nxt = cur;
      if (rise_ref && rise_fbk) begin
         nxt = PUMP_OFF;
      end else begin
         case (cur)
            PUMP_OFF: begin
               if (rise_ref)      nxt = PUMP_UP;
               else if (rise_fbk) nxt = PUMP_DN;
            end
            PUMP_UP:  if (rise_fbk) nxt = PUMP_OFF;
            PUMP_DN:  if (rise_ref) nxt = PUMP_OFF;
            default:  nxt = PUMP_OFF;
         endcase
      end
      return nxt;
   endfunction

endpackage

// File: rtl/pfd_sync.sv
module pfd_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst,
   input  logic d_i,
   output logic q_o
);

   localparam int LAST = STAGES - 1;

   if (STAGES < 2) begin : g_bad_depth
      $error("pfd_sync: STAGES must be at least 2");
   end

   logic [LAST:0] chain_q;

   always_ff @(posedge clk) begin
      if (rst) chain_q <= '0;
      else     chain_q <= {chain_q[LAST-1:0], d_i};
   end

   assign q_o = chain_q[LAST];

endmodule

// File: rtl/pfd_fsm.sv
module pfd_fsm
   import pfd_pkg::*;
(
   input  logic  clk,
   input  logic  rst,
   input  logic  ref_s,
   input  logic  fbk_s,
   output pump_e mode_o
);

   pfd_state_t st_q, st_d;
   logic       rise_ref, rise_fbk;

   // Edge detection against the levels held inside the state
   assign rise_ref = ref_s & ~st_q.ref_lvl;
   assign rise_fbk = fbk_s & ~st_q.fbk_lvl;

   always_comb begin
      st_d         = st_q;
      st_d.mode    = pfd_step(st_q.mode, rise_ref, rise_fbk);
      st_d.ref_lvl = ref_s;
      st_d.fbk_lvl = fbk_s;
   end

   always_ff @(posedge clk) begin
      if (rst) st_q <= PFD_IDLE_STATE;
      else     st_q <= st_d;
   end

   assign mode_o = st_q.mode;

   AST_RESET_IDLE: assert property (@(posedge clk) rst |=> st_q.mode == PUMP_OFF); // R8
   AST_COINCIDENT_IDLE: assert property (@(posedge clk) disable iff (rst)
      (rise_ref && rise_fbk) |=> st_q.mode == PUMP_OFF); // R4
   AST_UP_START: assert property (@(posedge clk) disable iff (rst)
      (st_q.mode == PUMP_OFF && rise_ref && !rise_fbk) |=> st_q.mode == PUMP_UP); // R2
   AST_UP_STOP: assert property (@(posedge clk) disable iff (rst)
      (st_q.mode == PUMP_UP && rise_fbk && !rise_ref) |=> st_q.mode == PUMP_OFF); // R2
   AST_DN_START: assert property (@(posedge clk) disable iff (rst)
      (st_q.mode == PUMP_OFF && rise_fbk && !rise_ref) |=> st_q.mode == PUMP_DN); // R3
   AST_DN_STOP: assert property (@(posedge clk) disable iff (rst)
      (st_q.mode == PUMP_DN && rise_ref && !rise_fbk) |=> st_q.mode == PUMP_OFF); // R3
   AST_NO_EDGE_HOLD: assert property (@(posedge clk) disable iff (rst)
      (!rise_ref && !rise_fbk) |=> $stable(st_q.mode)); // R1
   AST_LEGAL_MODE: assert property (@(posedge clk) disable iff (rst)
      st_q.mode != pump_e'(2'b11)); // R6

endmodule

// File: rtl/pfd_drive.sv
module pfd_drive
   import pfd_pkg::*;
#(
   parameter bit OUT_REG = 1'b0
) (
   input  logic  clk,
   input  logic  rst,
   input  pump_e mode_i,
   output logic  up_o,
   output logic  dn_o,
   output logic  lock_o
);

   if (OUT_REG) begin : g_registered
      logic up_q, dn_q, lock_q;
      always_ff @(posedge clk) begin
         if (rst) begin
            up_q   <= 1'b0;
            dn_q   <= 1'b0;
            lock_q <= 1'b1;
         end else begin
            up_q   <= (mode_i == PUMP_UP);
            dn_q   <= (mode_i == PUMP_DN);
            lock_q <= (mode_i == PUMP_OFF);
         end
      end
      assign up_o   = up_q;
      assign dn_o   = dn_q;
      assign lock_o = lock_q;
   end else begin : g_direct
      assign up_o   = (mode_i == PUMP_UP);
      assign dn_o   = (mode_i == PUMP_DN);
      assign lock_o = (mode_i == PUMP_OFF);
   end

   AST_PUMP_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
      !(up_o && dn_o)); // R6
   AST_LOCK_IS_IDLE: assert property (@(posedge clk) disable iff (rst)
      lock_o == !(up_o || dn_o)); // R5

endmodule

// File: rtl/pfd_core.sv
module pfd_core
   import pfd_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter bit OUT_REG     = 1'b0
) (
   input  logic clk,
   input  logic rst,
   input  logic ref_i,
   input  logic fbk_i,
   output logic up_o,
   output logic dn_o,
   output logic lock_o
);

   localparam int N_INPUTS   = 2;
   localparam int IDX_REF    = 0;
   localparam int IDX_FBK    = 1;
   localparam int EDGE_DELAY = SYNC_STAGES + 1 + int'(OUT_REG);

   if (SYNC_STAGES < 2 || EDGE_DELAY > 16) begin : g_bad_params
      $error("pfd_core: SYNC_STAGES must lie between 2 and 15");
   end

   logic [N_INPUTS-1:0] raw_in, sync_in;
   pump_e               mode;

   assign raw_in[IDX_REF] = ref_i;
   assign raw_in[IDX_FBK] = fbk_i;

   for (genvar g = 0; g < N_INPUTS; g++) begin : g_sync
      pfd_sync #(.STAGES(SYNC_STAGES)) u_sync (
         .clk (clk),
         .rst (rst),
         .d_i (raw_in[g]),
         .q_o (sync_in[g])
      );
   end

   pfd_fsm u_fsm (
      .clk    (clk),
      .rst    (rst),
      .ref_s  (sync_in[IDX_REF]),
      .fbk_s  (sync_in[IDX_FBK]),
      .mode_o (mode)
   );

   pfd_drive #(.OUT_REG(OUT_REG)) u_drive (
      .clk    (clk),
      .rst    (rst),
      .mode_i (mode),
      .up_o   (up_o),
      .dn_o   (dn_o),
      .lock_o (lock_o)
   );

endmodule

// File: tb/pfd_core_tb.sv
`timescale 1ns/1ps
module pfd_core_tb;

   localparam int SYNC = 2;
   localparam bit OREG = 1'b0;
   localparam int LAT  = SYNC + 1 + int'(OREG);

   logic clk = 1'b0, rst = 1'b1, ref_i = 1'b0, fbk_i = 1'b0;
   logic up, dn, lock;
   int   n_chk = 0, n_fail = 0;
   bit   done = 1'b0;

   always #2.5 clk = ~clk;

   pfd_core #(.SYNC_STAGES(SYNC), .OUT_REG(OREG)) u_dut (
      .clk(clk), .rst(rst), .ref_i(ref_i), .fbk_i(fbk_i),
      .up_o(up), .dn_o(dn), .lock_o(lock)
   );

   task automatic check_eq(string req, string what, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   // Reference model: 0 idle, 1 raise, 2 lower
   int mm = 0, mm_prev = 0;
   bit mr = 0, mf = 0;
   logic [SYNC-1:0] pr = '0, pf = '0;

   function automatic int model_next(int cur, bit rr, bit rf);
      if (rr && rf) return 0;
      if (cur == 0) return rr ? 1 : (rf ? 2 : 0);
      if (cur == 1 && rf) return 0;
      if (cur == 2 && rr) return 0;
      return cur;
   endfunction

   always @(posedge clk) begin
      if (rst) begin
         mm = 0; mm_prev = 0; mr = 0; mf = 0; pr = '0; pf = '0;
      end else begin
         mm_prev = mm;
         mm = model_next(mm, pr[SYNC-1] & ~mr, pf[SYNC-1] & ~mf);
         mr = pr[SYNC-1];
         mf = pf[SYNC-1];
         pr = {pr[SYNC-2:0], ref_i};
         pf = {pf[SYNC-2:0], fbk_i};
      end
   end

   // Cycle-by-cycle comparison, sampled away from the active edge
   always @(negedge clk) begin
      if (!rst && !done) begin
         int e;
         e = OREG ? mm_prev : mm;
         check_eq("R6", "up and dn together", int'(up & dn), 0);
         check_eq("R2", "up vs model", int'(up), int'(e == 1));
         check_eq("R3", "dn vs model", int'(dn), int'(e == 2));
         check_eq("R5", "lock vs model", int'(lock), int'(e == 0));
      end
   end

   task automatic tick();
      @(negedge clk);
      #1;
   endtask

   task automatic do_reset();
      rst = 1'b1; ref_i = 1'b0; fbk_i = 1'b0;
      repeat (4) tick();
      check_eq("R8", "up in reset", int'(up), 0);
      check_eq("R8", "dn in reset", int'(dn), 0);
      check_eq("R8", "lock in reset", int'(lock), 1);
      rst = 1'b0;
      repeat (2) tick();
   endtask

   task automatic run_pair(int period, int ref_off, int fbk_off, int ref_hi, int fbk_hi,
                           int nper, output int ups, output int dns);
      ups = 0; dns = 0;
      for (int c = 0; c < period * nper; c++) begin
         @(negedge clk);
         if (c >= 2 * period) begin
            ups += int'(up);
            dns += int'(dn);
         end
         #1;
         ref_i = ((c - ref_off + period) % period) < ref_hi;
         fbk_i = ((c - fbk_off + period) % period) < fbk_hi;
      end
   endtask

   initial begin
      int ups, dns, lat;
      void'($urandom(32'd4046));

      do_reset();

      // R9 latency from a reference rise to up_o
      ref_i = 1'b1;
      lat = 0;
      for (int k = 1; k <= 10; k++) begin
         @(negedge clk);
         if (up && lat == 0) lat = k;
      end
      check_eq("R9", "edge-to-output cycles", lat, LAT);
      #1; fbk_i = 1'b1;
      repeat (6) tick();

      do_reset();
      run_pair(20, 0, 5, 10, 10, 8, ups, dns);
      check_eq("R2", "up cycles, reference leads by 5", ups, 6 * 5);
      check_eq("R2", "dn cycles, reference leads", dns, 0);

      do_reset();
      run_pair(20, 7, 0, 10, 10, 8, ups, dns);
      check_eq("R3", "dn cycles, feedback leads by 7", dns, 6 * 7);
      check_eq("R3", "up cycles, feedback leads", ups, 0);

      do_reset();
      run_pair(20, 0, 5, 2, 15, 8, ups, dns);
      check_eq("R1", "up cycles with skewed duty", ups, 6 * 5);
      do_reset();
      run_pair(24, 9, 0, 1, 20, 8, ups, dns);
      check_eq("R1", "dn cycles with skewed duty", dns, 6 * 9);

      do_reset();
      run_pair(16, 3, 3, 8, 4, 8, ups, dns);
      check_eq("R4", "pump cycles with aligned edges", ups + dns, 0);
      check_eq("R5", "lock held with aligned edges", int'(lock), 1);

      // R4 coincident rises while a raise request is active
      do_reset();
      ref_i = 1'b1;
      repeat (LAT + 1) tick();
      check_eq("R4", "raise active before coincident edges", int'(up), 1);
      ref_i = 1'b0;
      repeat (4) tick();
      check_eq("R1", "raise kept over reference fall", int'(up), 1);
      ref_i = 1'b1; fbk_i = 1'b1;
      repeat (LAT + 1) tick();
      check_eq("R4", "up after coincident edges", int'(up), 0);
      check_eq("R4", "dn after coincident edges", int'(dn), 0);

      // R8 reset taken from the lower mode
      ref_i = 1'b0; fbk_i = 1'b0;
      repeat (3) tick();
      fbk_i = 1'b1;
      repeat (LAT + 1) tick();
      check_eq("R8", "lower active before reset", int'(dn), 1);
      do_reset();

      // R7 reference absent, feedback running
      dns = 0;
      for (int c = 0; c < 200; c++) begin
         @(negedge clk);
         if (c >= 20) dns += int'(dn);
         #1; fbk_i = (c % 8) < 4;
      end
      check_eq("R7", "dn cycles with no reference", dns, 180);

      // R7 reference faster than feedback
      do_reset();
      ups = 0; dns = 0;
      for (int c = 0; c < 420; c++) begin
         @(negedge clk);
         ups += int'(up);
         dns += int'(dn);
         #1;
         ref_i = (c % 10) < 5;
         fbk_i = ((c + 3) % 14) < 7;
      end
      check_eq("R7", "dn never with faster reference", dns, 0);
      check_eq("R7", "up present with faster reference", int'(ups > 100), 1);

      // Random toggling with occasional reset
      do_reset();
      for (int c = 0; c < 4000; c++) begin
         tick();
         if ($urandom_range(2, 0) == 0) ref_i = ~ref_i;
         if ($urandom_range(3, 0) == 0) fbk_i = ~fbk_i;
         rst = ($urandom_range(599, 0) == 0);
      end
      rst = 1'b0;
      repeat (4) tick();

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      #(5.0 * 150000);
      if (!done) begin
         done = 1'b1;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

endmodule